// File: doc/BRIEF.md
# Link Power-Down Ready Sequencer

This block runs the orderly shutdown of a link from the root side once software has asked for the deepest device power state with main power removed. It sends a turn-off broadcast to a configurable set of downstream ports and gathers one acknowledgement from each enabled port. Once the set is complete, it sends the link-level entry message for the powered-down link states. It then waits for the receiver to report electrical idle and holds off for a fixed number of reference-clock cycles before it raises its main-power-off output.

When power is off, the block reports one of two end states. The first is the auxiliary-power state, used when the auxiliary rail is kept. The second is the no-power state, used when it is not. Only the auxiliary-power state watches the wake input. A wake there makes the block drop the power-off request and ask for power restore together with a fundamental reset. The block then stays in that state until its own reset, which stands for the fundamental reset. If the acknowledgements do not all arrive within a programmable window, the sequence aborts back to the running link and raises a flag.

Top module: `l23_ready_seq`

## Requirements
- R1: After reset, every output is low: no broadcast, no entry message, power on, neither end state, no restore, no fundamental reset, no timeout flag.
- R2: A high `d3cold_req` sampled while idle makes `turnoff_send` high for exactly one cycle, in the cycle after the sampling edge.
- R3: `enter_l23_send` pulses for one cycle, in the cycle after the edge at which every enabled bit of `port_en` has had its `ack_in` bit seen. Acknowledgements accumulate across cycles, an empty `port_en` counts as complete at once, and `ack_in` bits of disabled ports are ignored.
- R4: If the set is still incomplete at the ACK_TIMEOUT-th edge after the broadcast cycle, the block returns to idle without an entry message and sets `ack_timeout`. The flag holds until the next accepted request clears it.
- R5: If the last missing acknowledgement arrives on that same timeout edge, completion wins: the entry message is sent and `ack_timeout` stays low.
- R6: `main_pwr_off` rises exactly HOLD_CYCLES cycles after the first edge at which `elec_idle` is sampled high following the entry message, and it never rises before the entry message.
- R7: Once power is off, `in_l2` is high if `aux_keep` was high at the end of the hold-off, and `in_l3` is high otherwise. At most one of them is high at any time.
- R8: In the auxiliary-power state, a high `wake_in` moves the block, from the next cycle onward, to restore. In restore, `main_pwr_off` and `in_l2` are low, and `restore_req` and `fund_reset` are high. This holds until reset.
- R9: In the no-power state, `wake_in` is ignored: `in_l3` and `main_pwr_off` stay high and `restore_req` stays low.
- R10: `d3cold_req` is ignored outside idle: it produces no further `turnoff_send` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset, also the fundamental reset exit |
| d3cold_req | input | 1 | Software request to power the link down |
| port_en | input | NPORTS | Downstream ports that must acknowledge |
| aux_keep | input | 1 | Auxiliary power is kept after shutdown |
| ack_in | input | NPORTS | Per-port turn-off acknowledgement |
| elec_idle | input | 1 | Link has reached electrical idle |
| wake_in | input | 1 | Beacon or sideband wake indication |
| turnoff_send | output | 1 | Send the turn-off broadcast (one-cycle pulse) |
| enter_l23_send | output | 1 | Send the powered-down entry message (one-cycle pulse) |
| main_pwr_off | output | 1 | Request removal of main power |
| in_l2 | output | 1 | Powered down with auxiliary power kept |
| in_l3 | output | 1 | Powered down with no power |
| restore_req | output | 1 | Request main power restore |
| fund_reset | output | 1 | Request a fundamental reset of the link |
| ack_timeout | output | 1 | Acknowledgement collection timed out |

## Verification
The acknowledgement window can close on the same edge at which the last missing acknowledgement arrives, so completion and timeout fall in one cycle. The bench provokes this by holding back one group of acknowledgements and delivering it exactly before the ACK_TIMEOUT-th edge of the wait. It judges the result at the ports: the entry pulse must appear in the next cycle, `ack_timeout` must stay low, and power-off must follow. A companion vector leaves one port silent through that same edge and must see the flag instead.

// File: rtl/l23_ready_seq.sv
module l23_ready_seq #(
  parameter int NPORTS      = 4,
  parameter int ACK_TIMEOUT = 64,
  parameter int HOLD_CYCLES = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d3cold_req,
  input  logic [NPORTS-1:0] port_en,
  input  logic              aux_keep,
  input  logic [NPORTS-1:0] ack_in,
  input  logic              elec_idle,
  input  logic              wake_in,
  output logic              turnoff_send,
  output logic              enter_l23_send,
  output logic              main_pwr_off,
  output logic              in_l2,
  output logic              in_l3,
  output logic              restore_req,
  output logic              fund_reset,
  output logic              ack_timeout
);

  localparam int CNT_MAX = (ACK_TIMEOUT > HOLD_CYCLES) ? ACK_TIMEOUT : HOLD_CYCLES;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] ACK_LAST  = CW'(ACK_TIMEOUT - 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYCLES - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_BCAST, S_WACK, S_ENTER, S_WIDLE, S_HOLD, S_OFF2, S_OFF3, S_RESTORE
  } st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [NPORTS-1:0] got;
  logic [NPORTS-1:0] got_nx;
  logic              all_in;
  logic              to_flag;

  assign got_nx = got | (ack_in & port_en);
  assign all_in = ((got_nx & port_en) == port_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      got     <= '0;
      to_flag <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (d3cold_req) begin
          st      <= S_BCAST;
          got     <= '0;
          to_flag <= 1'b0;
        end
        S_BCAST: begin
          got <= got_nx;
          cnt <= '0;
          st  <= S_WACK;
        end
        S_WACK: begin
          got <= got_nx;
          if (all_in) st <= S_ENTER;
          else if (cnt == ACK_LAST) begin
            st      <= S_IDLE;
            to_flag <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        S_ENTER: st <= S_WIDLE;
        S_WIDLE: if (elec_idle) begin
          st  <= S_HOLD;
          cnt <= '0;
        end
        S_HOLD: begin
          if (cnt == HOLD_LAST) st <= aux_keep ? S_OFF2 : S_OFF3;
          else cnt <= cnt + 1'b1;
        end
        S_OFF2: if (wake_in) st <= S_RESTORE;
        S_OFF3: st <= S_OFF3;
        S_RESTORE: st <= S_RESTORE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign turnoff_send   = (st == S_BCAST);
  assign enter_l23_send = (st == S_ENTER);
  assign main_pwr_off   = (st == S_OFF2) || (st == S_OFF3);
  assign in_l2          = (st == S_OFF2);
  assign in_l3          = (st == S_OFF3);
  assign restore_req    = (st == S_RESTORE);
  assign fund_reset     = (st == S_RESTORE);
  assign ack_timeout    = to_flag;

endmodule

// File: rtl/l23_ready_seq_chk.sv
module l23_ready_seq_chk #(
  parameter int HOLD_CYCLES = 13
) (
  input logic clk,
  input logic rst_n,
  input logic elec_idle,
  input logic turnoff_send,
  input logic enter_l23_send,
  input logic main_pwr_off,
  input logic in_l2,
  input logic in_l3,
  input logic restore_req,
  input logic fund_reset,
  input logic ack_timeout
);

  localparam int IW = $clog2(HOLD_CYCLES + 2);
  localparam logic [IW-1:0] ISAT = IW'(HOLD_CYCLES + 1);

  logic          seen_entry;
  logic [IW-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_entry <= 1'b0;
      idle_cnt   <= '0;
    end else begin
      if (enter_l23_send) seen_entry <= 1'b1;
      if (seen_entry && (elec_idle || idle_cnt != '0) && idle_cnt != ISAT)
        idle_cnt <= idle_cnt + 1'b1;
    end
  end

  p_turnoff_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    turnoff_send |=> !turnoff_send);

  p_entry_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    enter_l23_send |=> !enter_l23_send);

  p_abort_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_timeout) |-> !enter_l23_send && !main_pwr_off);

  p_power_after_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    main_pwr_off |-> seen_entry);

  p_holdoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_pwr_off) |-> idle_cnt >= IW'(HOLD_CYCLES));

  p_one_end_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_l2, in_l3, restore_req}));

  p_restore_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fund_reset |=> fund_reset && restore_req && !main_pwr_off && !in_l2);

  p_l3_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_l3 |=> in_l3 && main_pwr_off && !restore_req);

endmodule

bind l23_ready_seq l23_ready_seq_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .elec_idle(elec_idle),
  .turnoff_send(turnoff_send), .enter_l23_send(enter_l23_send),
  .main_pwr_off(main_pwr_off), .in_l2(in_l2), .in_l3(in_l3),
  .restore_req(restore_req), .fund_reset(fund_reset), .ack_timeout(ack_timeout)
);

// File: tb/test_l23_ready_seq.sv
`timescale 1ns/1ps
module test_l23_ready_seq;
  localparam int NP = 4;
  localparam int TO = 16;
  localparam int HC = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic d3cold_req = 1'b0;
  logic [NP-1:0] port_en = '0;
  logic aux_keep = 1'b0;
  logic [NP-1:0] ack_in = '0;
  logic elec_idle = 1'b0;
  logic wake_in = 1'b0;
  logic turnoff_send, enter_l23_send, main_pwr_off, in_l2, in_l3;
  logic restore_req, fund_reset, ack_timeout;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  l23_ready_seq #(.NPORTS(NP), .ACK_TIMEOUT(TO), .HOLD_CYCLES(HC)) i_l23_ready_seq (
    .clk(clk), .rst_n(rst_n), .d3cold_req(d3cold_req), .port_en(port_en),
    .aux_keep(aux_keep), .ack_in(ack_in), .elec_idle(elec_idle), .wake_in(wake_in),
    .turnoff_send(turnoff_send), .enter_l23_send(enter_l23_send),
    .main_pwr_off(main_pwr_off), .in_l2(in_l2), .in_l3(in_l3),
    .restore_req(restore_req), .fund_reset(fund_reset), .ack_timeout(ack_timeout)
  );

  // en[20:17] a1[16:13] a2[12:9] d2[8:1] aux[0]
  localparam logic [20:0] VEC [7] = '{
    {4'hF, 4'hF, 4'h0, 8'd2,  1'b1},
    {4'hF, 4'h3, 4'hC, 8'd5,  1'b0},
    {4'h5, 4'h0, 4'hF, 8'd9,  1'b1},
    {4'hF, 4'h7, 4'h0, 8'd16, 1'b1},
    {4'hF, 4'h1, 4'hE, 8'd16, 1'b0},
    {4'h0, 4'h0, 4'h0, 8'd2,  1'b1},
    {4'hA, 4'h5, 4'h0, 8'd16, 1'b0}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    d3cold_req = 1'b0; ack_in = '0; elec_idle = 1'b0; wake_in = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic finish_power(input logic aux);
    tick();
    chk("R3 entry pulse ends", enter_l23_send, 0);
    elec_idle = 1'b1;
    tick();
    repeat (HC - 1) tick();
    chk("R6 power still on before hold-off", main_pwr_off, 0);
    tick();
    chk("R6 power off after hold-off", main_pwr_off, 1);
    chk("R7 aux state", in_l2, aux);
    chk("R7 no-power state", in_l3, !aux);
    elec_idle = 1'b0;
  endtask

  task automatic run_full(input logic aux);
    port_en = '1; aux_keep = aux;
    d3cold_req = 1'b1; tick(); d3cold_req = 1'b0; tick();
    ack_in = '1; tick(); ack_in = '0;
    chk("R3 entry after all acks", enter_l23_send, 1);
    finish_power(aux);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 turnoff", turnoff_send, 0);
    chk("R1 entry", enter_l23_send, 0);
    chk("R1 power", main_pwr_off, 0);
    chk("R1 states", {in_l2, in_l3, restore_req, fund_reset}, 0);
    chk("R1 flag", ack_timeout, 0);

    for (int v = 0; v < 7; v++) begin
      logic [3:0] en, a1, a2;
      int d2;
      logic aux, c1, call;
      en = VEC[v][20:17]; a1 = VEC[v][16:13]; a2 = VEC[v][12:9];
      d2 = int'(VEC[v][8:1]); aux = VEC[v][0];
      c1 = ((a1 & en) == en);
      call = (((a1 | a2) & en) == en);
      do_reset();
      port_en = en; aux_keep = aux;
      d3cold_req = 1'b1; tick(); d3cold_req = 1'b0;
      chk("R2 broadcast pulse", turnoff_send, 1);
      tick();
      chk("R2 broadcast one cycle", turnoff_send, 0);
      ack_in = a1; tick(); ack_in = '0;
      if (c1) begin
        chk("R3 entry at first edge", enter_l23_send, 1);
        finish_power(aux);
      end else begin
        for (int k = 2; k < d2; k++) begin
          tick();
          chk("R3 no entry while incomplete", enter_l23_send, 0);
        end
        ack_in = a2; tick(); ack_in = '0;
        if (call) begin
          chk((d2 == TO) ? "R5 completion wins on timeout edge" : "R3 entry after late acks",
              enter_l23_send, 1);
          chk("R5 no flag on completion", ack_timeout, 0);
          finish_power(aux);
        end else begin
          chk("R3 disabled or missing ack gives no entry", enter_l23_send, 0);
          for (int k = d2; k < TO; k++) tick();
          chk("R4 timeout flag", ack_timeout, 1);
          chk("R4 power stays on", main_pwr_off, 0);
          tick();
          chk("R4 no entry after abort", enter_l23_send, 0);
        end
      end
    end

    // R4: flag cleared by next accepted request; R10: request held outside idle
    do_reset();
    port_en = '1; aux_keep = 1'b1;
    d3cold_req = 1'b1; tick(); d3cold_req = 1'b0; tick();
    repeat (TO) tick();
    chk("R4 flag after window", ack_timeout, 1);
    d3cold_req = 1'b1; tick();
    chk("R4 flag cleared by new request", ack_timeout, 0);
    chk("R2 broadcast after abort", turnoff_send, 1);
    tick();
    chk("R10 held request no second pulse", turnoff_send, 0);
    tick();
    chk("R10 held request still ignored", turnoff_send, 0);
    d3cold_req = 1'b0;
    ack_in = '1; tick(); ack_in = '0;
    chk("R3 entry in retry", enter_l23_send, 1);
    finish_power(1'b1);
    d3cold_req = 1'b1; tick(); d3cold_req = 1'b0;
    chk("R10 request ignored when off", turnoff_send, 0);
    chk("R10 stays in aux state", in_l2, 1);

    wake_in = 1'b1; tick(); wake_in = 1'b0;
    chk("R8 restore request", restore_req, 1);
    chk("R8 fundamental reset", fund_reset, 1);
    chk("R8 power on", main_pwr_off, 0);
    chk("R8 left aux state", in_l2, 0);
    repeat (3) tick();
    chk("R8 restore held", {restore_req, fund_reset}, 2'b11);

    do_reset();
    run_full(1'b0);
    wake_in = 1'b1; repeat (4) tick(); wake_in = 1'b0;
    chk("R9 no-power state kept", in_l3, 1);
    chk("R9 power stays off", main_pwr_off, 1);
    chk("R9 no restore", restore_req, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule